// File: doc/BRIEF.md
# Transition-Table Event Counter

This block counts events on up to three digital lines. It does not use a fixed edge or quadrature decoder. On every clock it joins the previous and the current level vector of the selected lines into a six-bit index. It then looks that index up in a 64-entry table that software writes.

Each table entry holds a two-bit action and a capture bit:

- The action can increment the count, decrement it, leave it alone, or mark the transition as illegal.
- The capture bit copies the count, as it stood before the action, into a 16-deep FIFO and raises an interrupt flag. The action still takes effect in the same cycle.

A routing field picks which physical line feeds each of the three table bit positions. A lane-count input masks the unused positions to zero, so one-, two- and three-line schemes share one table. Examples are edge counters, gated counters, direction/step counters and quadrature decoders.

Top module: `trans_event_counter`

## Requirements
- R1: After reset the count is 0, the error, interrupt and overflow flags are 0, the FIFO is empty, and every table entry is 3'b000 (no change).
- R2: A table entry is {capture, action[1:0]}, with action 00 = no change, 01 = +1 and 10 = -1. The entry is addressed by {previous[2:0], current[2:0]}, so the previous vector sits in address bits 5:3.
- R3: When the previous and current vectors are equal, no table entry acts: the count, the flags and the FIFO stay unchanged, whatever is stored at that index.
- R4: Action 11 leaves the count unchanged and sets a sticky error flag. The flag holds until flag_clr is asserted. flag_clr clears the error, interrupt and overflow flags, and it wins over a set in the same cycle.
- R5: An entry with the capture bit set pushes the count from before the update into the FIFO and sets the sticky interrupt flag. Its action is still applied in the same cycle.
- R6: A capture attempted while the FIFO holds 16 values is dropped and sets a sticky overflow flag. The count still updates.
- R7: route_sel[2k+1:2k] selects which physical line of in_lines drives vector bit k, for k = 0, 1, 2.
- R8: lane_count = 1 uses vector bit 0 only, and lane_count = 2 uses bits 1:0. Any other value uses all three bits. Unused bits read as 0, so their lines cannot cause transitions.
- R9: cnt_clear sets the count to 0 on the next edge and takes priority over any action.
- R10: The FIFO returns captured values oldest first. cap_data shows the head while cap_valid is 1, cap_rd pops one value, and cap_rd on an empty FIFO has no effect.
- R11: Each line passes through two synchronizing flops. A level change driven before clock edge 1 changes the count at edge 3, and not earlier.
- R12: The count is 32-bit two's complement and wraps: 0 - 1 gives 32'hFFFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_lines | input | 4 | Asynchronous physical event lines |
| route_sel | input | 6 | Two-bit line select for each of the three vector bits |
| lane_count | input | 2 | Number of vector bits in use (1, 2, otherwise 3) |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 6 | Table index {previous, current} |
| tbl_wdata | input | 3 | Entry {capture, action} |
| cnt_clear | input | 1 | Synchronous count clear |
| flag_clr | input | 1 | Clears the error, interrupt and overflow flags |
| cap_rd | input | 1 | Pop the FIFO head |
| count | output | 32 | Live count |
| err_flag | output | 1 | Sticky illegal-transition flag |
| irq_flag | output | 1 | Sticky capture interrupt flag |
| cap_data | output | 32 | FIFO head value |
| cap_valid | output | 1 | FIFO not empty |
| cap_ovf | output | 1 | Sticky capture overflow flag |

## Verification
The properties assume that every line holds its level for at least three clocks, so each change shows up as one transition after synchronization. They also assume that the lines are low through reset, and that route_sel and lane_count change only while the routed levels are zero. Otherwise a reconfiguration looks like a transition and acts through the table. The directed stimulus changes lines only at falling edges and waits four clocks after each change. It reprograms routing only with all lines low. It raises cnt_clear and flag_clr only while no transition is in flight, so each count step and each flag change can be checked alone.

// File: rtl/trans_event_counter.sv
module trans_event_counter #(
  parameter int PHYS_W     = 4,
  parameter int CNT_W      = 32,
  parameter int FIFO_DEPTH = 16   // power of two
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [PHYS_W-1:0]             in_lines,
  input  logic [3*$clog2(PHYS_W)-1:0]   route_sel,
  input  logic [1:0]                    lane_count,
  input  logic                          tbl_we,
  input  logic [5:0]                    tbl_addr,
  input  logic [2:0]                    tbl_wdata,
  input  logic                          cnt_clear,
  input  logic                          flag_clr,
  input  logic                          cap_rd,
  output logic [CNT_W-1:0]              count,
  output logic                          err_flag,
  output logic                          irq_flag,
  output logic [CNT_W-1:0]              cap_data,
  output logic                          cap_valid,
  output logic                          cap_ovf
);
  localparam int SEL_W = $clog2(PHYS_W);
  localparam int AW    = $clog2(FIFO_DEPTH);
  localparam int TBL_N = 64;
  localparam logic [AW:0] LVL_FULL = (AW+1)'(FIFO_DEPTH);

  logic [PHYS_W-1:0] sync1, sync2;
  logic [2:0]        routed, lane_mask, cur_vec, prev_vec;
  logic [2:0]        tbl [TBL_N];
  logic [2:0]        entry;
  logic              moved, cap_req, cap_push, cap_pop, fifo_full;
  logic [1:0]        act;
  logic [CNT_W-1:0]  fifo_mem [FIFO_DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [AW:0]       fifo_level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= in_lines;
      sync2 <= sync1;
    end
  end

  for (genvar k = 0; k < 3; k++) begin : g_route
    assign routed[k] = sync2[route_sel[k*SEL_W +: SEL_W]];
  end

  assign lane_mask = (lane_count == 2'd1) ? 3'b001 :
                     (lane_count == 2'd2) ? 3'b011 : 3'b111;
  assign cur_vec   = routed & lane_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_vec <= '0;
    else        prev_vec <= cur_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TBL_N; i++) tbl[i] <= '0;
    end else if (tbl_we) begin
      tbl[tbl_addr] <= tbl_wdata;
    end
  end

  assign moved   = (prev_vec != cur_vec);
  assign entry   = tbl[{prev_vec, cur_vec}];
  assign act     = moved ? entry[1:0] : 2'b00;
  assign cap_req = moved & entry[2];

  always_ff @(posedge clk) begin
    if (!rst_n)         count <= '0;
    else if (cnt_clear) count <= '0;
    else begin
      case (act)
        2'b01:   count <= count + CNT_W'(1);
        2'b10:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign fifo_full = (fifo_level == LVL_FULL);
  assign cap_push  = cap_req & ~fifo_full;
  assign cap_pop   = cap_rd & cap_valid;
  assign cap_valid = (fifo_level != '0);
  assign cap_data  = fifo_mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (cap_push) fifo_mem[wr_ptr] <= count;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      fifo_level <= '0;
    end else begin
      if (cap_push) wr_ptr <= wr_ptr + AW'(1);
      if (cap_pop)  rd_ptr <= rd_ptr + AW'(1);
      case ({cap_push, cap_pop})
        2'b10:   fifo_level <= fifo_level + (AW+1)'(1);
        2'b01:   fifo_level <= fifo_level - (AW+1)'(1);
        default: fifo_level <= fifo_level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flag_clr) begin
      err_flag <= 1'b0;
      irq_flag <= 1'b0;
      cap_ovf  <= 1'b0;
    end else begin
      if (act == 2'b11)         err_flag <= 1'b1;
      if (cap_req)              irq_flag <= 1'b1;
      if (cap_req && fifo_full) cap_ovf  <= 1'b1;
    end
  end
endmodule

// File: rtl/trans_event_counter_chk.sv
module trans_event_counter_chk #(
  parameter int CNT_W      = 32,
  parameter int FIFO_DEPTH = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cnt_clear,
  input logic                          flag_clr,
  input logic                          cap_rd,
  input logic [CNT_W-1:0]              count,
  input logic                          err_flag,
  input logic                          irq_flag,
  input logic                          cap_ovf,
  input logic                          cap_valid,
  input logic [2:0]                    prev_vec,
  input logic [2:0]                    cur_vec,
  input logic                          cap_push,
  input logic [$clog2(FIFO_DEPTH):0]   fifo_level
);
  localparam int AW = $clog2(FIFO_DEPTH);
  localparam logic [AW:0] LVL_MAX = (AW+1)'(FIFO_DEPTH);

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> count == '0); // R9
  AST_STEP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clear |=> (count == $past(count) || count == $past(count) + CNT_W'(1)
                    || count == $past(count) - CNT_W'(1))); // R2
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_vec == cur_vec && !cnt_clear) |=> $stable(count)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !flag_clr) |=> err_flag); // R4
  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> (!err_flag && !irq_flag && !cap_ovf)); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ovf && !flag_clr) |=> cap_ovf); // R6
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_MAX); // R6
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_valid && cap_rd && !cap_push) |=> !cap_valid); // R10
endmodule

bind trans_event_counter trans_event_counter_chk #(
  .CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_clear(cnt_clear), .flag_clr(flag_clr),
  .cap_rd(cap_rd), .count(count), .err_flag(err_flag), .irq_flag(irq_flag),
  .cap_ovf(cap_ovf), .cap_valid(cap_valid), .prev_vec(prev_vec),
  .cur_vec(cur_vec), .cap_push(cap_push), .fifo_level(fifo_level)
);

// File: tb/trans_event_counter_tb.sv
module trans_event_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  in_lines = '0;
  logic [5:0]  route_sel = 6'b10_01_00;
  logic [1:0]  lane_count = 2'd3;
  logic        tbl_we = 1'b0;
  logic [5:0]  tbl_addr = '0;
  logic [2:0]  tbl_wdata = '0;
  logic        cnt_clear = 1'b0, flag_clr = 1'b0, cap_rd = 1'b0;
  logic [31:0] count, cap_data;
  logic        err_flag, irq_flag, cap_valid, cap_ovf;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  trans_event_counter u_dut (
    .clk(clk), .rst_n(rst_n), .in_lines(in_lines), .route_sel(route_sel),
    .lane_count(lane_count), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .cnt_clear(cnt_clear), .flag_clr(flag_clr),
    .cap_rd(cap_rd), .count(count), .err_flag(err_flag), .irq_flag(irq_flag),
    .cap_data(cap_data), .cap_valid(cap_valid), .cap_ovf(cap_ovf)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic wr_tbl(input logic [5:0] a, input logic [2:0] d);
    @(negedge clk); tbl_we = 1'b1; tbl_addr = a; tbl_wdata = d;
    @(negedge clk); tbl_we = 1'b0;
  endtask

  task automatic drive(input logic [3:0] v);
    @(negedge clk); in_lines = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk); cnt_clear = 1'b1;
    @(negedge clk); cnt_clear = 1'b0;
  endtask

  task automatic pulse_flag_clr();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic pop(output logic [31:0] v);
    @(negedge clk); v = cap_data; cap_rd = 1'b1;
    @(negedge clk); cap_rd = 1'b0;
  endtask

  task automatic t_reset();
    check(count == 0, "R1 count", count, 0);
    check({err_flag, irq_flag, cap_ovf, cap_valid} == 4'b0, "R1 flags",
          {err_flag, irq_flag, cap_ovf, cap_valid}, 0);
    drive(4'b0001); drive(4'b0000);
    check(count == 0, "R1 table no-change", count, 0);
  endtask

  task automatic t_quad();
    lane_count = 2'd2;
    wr_tbl(6'o01, 3'b001); wr_tbl(6'o13, 3'b001);
    wr_tbl(6'o32, 3'b001); wr_tbl(6'o20, 3'b001);
    wr_tbl(6'o02, 3'b010); wr_tbl(6'o23, 3'b010);
    wr_tbl(6'o31, 3'b010); wr_tbl(6'o10, 3'b010);
    drive(4'b0001); drive(4'b0011); drive(4'b0010); drive(4'b0000);
    check(count == 4, "R2 quad forward", count, 4);
    drive(4'b0010); drive(4'b0011);
    check(count == 2, "R2 quad reverse", count, 2);
    drive(4'b0111);
    check(count == 2, "R8 masked lane", count, 2);
    drive(4'b0011);
    check(count == 2, "R8 masked lane back", count, 2);
  endtask

  task automatic t_latency();
    @(negedge clk); in_lines = 4'b0001;
    repeat (2) @(negedge clk);
    check(count == 2, "R11 not before edge 3", count, 2);
    @(negedge clk);
    check(count == 1, "R11 at edge 3", count, 1);
    repeat (2) @(negedge clk);
    drive(4'b0000);
    check(count == 0, "R2 decrement", count, 0);
  endtask

  task automatic t_equal();
    lane_count = 2'd3;
    wr_tbl(6'o00, 3'b101); wr_tbl(6'o77, 3'b101);
    repeat (10) @(negedge clk);
    check(count == 0 && !cap_valid && !irq_flag, "R3 steady low", count, 0);
    wr_tbl(6'o07, 3'b000); wr_tbl(6'o70, 3'b000);
    drive(4'b0111);
    repeat (10) @(negedge clk);
    check(count == 0 && !cap_valid && !irq_flag, "R3 steady high", count, 0);
    drive(4'b0000);
  endtask

  task automatic t_error();
    wr_tbl(6'o07, 3'b011);
    drive(4'b0111);
    check(err_flag == 1'b1, "R4 error set", err_flag, 1);
    check(count == 0, "R4 count held", count, 0);
    drive(4'b0000);
    check(err_flag == 1'b1, "R4 sticky", err_flag, 1);
    pulse_flag_clr();
    check(err_flag == 1'b0, "R4 cleared", err_flag, 0);
  endtask

  task automatic t_capture();
    logic [31:0] v;
    wr_tbl(6'o01, 3'b101); wr_tbl(6'o10, 3'b001);
    for (int i = 0; i < 3; i++) begin
      drive(4'b0001); drive(4'b0000);
    end
    check(count == 6, "R5 count with capture", count, 6);
    check(irq_flag == 1'b1, "R5 irq", irq_flag, 1);
    for (int i = 0; i < 3; i++) begin
      check(cap_valid == 1'b1, "R10 valid", cap_valid, 1);
      pop(v);
      check(v == 32'(2 * i), "R5 captured value", v, 32'(2 * i));
    end
    check(cap_valid == 1'b0, "R10 empty", cap_valid, 0);
    pop(v);
    check(cap_valid == 1'b0 && count == 6, "R10 pop on empty", cap_valid, 0);
    pulse_flag_clr();
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    pulse_clear();
    wr_tbl(6'o10, 3'b000);
    for (int i = 0; i < 18; i++) begin
      drive(4'b0001); drive(4'b0000);
    end
    check(count == 18, "R6 count keeps updating", count, 18);
    check(cap_ovf == 1'b1, "R6 overflow", cap_ovf, 1);
    for (int i = 0; i < 16; i++) begin
      pop(v);
      check(v == 32'(i), "R6 kept values", v, 32'(i));
    end
    check(cap_valid == 1'b0, "R6 dropped captures", cap_valid, 0);
    check(cap_ovf == 1'b1, "R6 ovf sticky", cap_ovf, 1);
    pulse_flag_clr();
    check(cap_ovf == 1'b0, "R6 ovf cleared", cap_ovf, 0);
  endtask

  task automatic t_clear_wrap();
    pulse_clear();
    check(count == 0, "R9 clear", count, 0);
    wr_tbl(6'o01, 3'b010);
    drive(4'b0001);
    check(count == 32'hFFFF_FFFF, "R12 wrap", count, 32'hFFFF_FFFF);
    drive(4'b0000);
    pulse_clear();
    check(count == 0, "R9 clear after wrap", count, 0);
  endtask

  task automatic t_route();
    route_sel = 6'b10_01_11;
    lane_count = 2'd1;
    wr_tbl(6'o01, 3'b001); wr_tbl(6'o10, 3'b000);
    drive(4'b0001); drive(4'b0000);
    check(count == 0, "R7 unrouted line", count, 0);
    drive(4'b1000); drive(4'b0000);
    check(count == 1, "R7 routed line", count, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", checks, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_quad();
    t_latency();
    t_equal();
    t_error();
    t_capture();
    t_overflow();
    t_clear_wrap();
    t_route();
    summary();
  end
endmodule